// File: doc/BRIEF.md
# PCI Type-0 Configuration Header Register File

This block holds the 64-byte type-0 configuration header of a single PCI endpoint function. Configuration software reaches it through a request/response port that carries byte, halfword and word accesses. The identification fields are fixed by parameters. Command, status, cache line size, latency timer, interrupt line and the expansion ROM register can be written. Six base address registers follow the size-probe and programming protocol.

Each base address register drives a decoded base, a size and a valid flag toward the address decode logic downstream. When software programs a new nonzero base, the register raises a one-cycle update pulse. A register can instead be tied to a fixed I/O address; it then reads as zero and ignores writes.

The request side follows valid/ready rules. A request is taken on a rising edge where `req_valid` and `req_ready` are both high. Its response appears on the next cycle and is held, unchanged, until `rsp_ready` is seen high. `req_ready` is low only while an earlier response is stalled. Requests are not queued.

Top module: `cfghdr_regfile`

## Requirements
- R1: `req_ready` equals `!rsp_valid || rsp_ready`. An accepted request gives `rsp_valid` high on the next cycle. While `rsp_ready` is low, `rsp_valid`, `rsp_rdata` and `rsp_err` hold their values, and a request offered during that time is not accepted.
- R2: `req_size` encodes 0 = byte, 1 = halfword, 2 = word; code 3 returns `rsp_err`=1 and changes nothing. Reads return the bytes at offset, offset+1, … right-aligned and little-endian, with zero upper bits. Errored or write responses carry zero data.
- R3: A request at offset 0x40 or above returns `rsp_err`=1 and changes no register.
- R4: After reset, and whatever is written, the identification fields read their parameter values. The little-endian layout is vendor 0x00, device 0x02, revision 0x08, prog-if 0x09, subclass 0x0A, class 0x0B, header type 0x0E, BIST 0x0F, subsystem vendor 0x2C, subsystem 0x2E, interrupt pin 0x3D, min grant 0x3E, max latency 0x3F.
- R5: Rules for byte writes:
  - Byte writes store at cache line size 0x0C, latency timer 0x0D and interrupt line 0x3C.
  - At 0x08, 0x0B, 0x3D, 0x3E and 0x3F they are dropped with no error.
  - At any other offset they return an error.
- R6: Halfword writes store the command at 0x04 and the status at 0x06. A halfword write at 0x0C stores its low byte into cache line size. A halfword write at any other offset returns an error.
- R7: A word write at 0x04 stores data bits 15:0 into command and bits 31:16 into status. A word write at an offset that is not 0x04, the ROM register or a BAR (0x10 + 4·n) is dropped with no error.
- R8: Writing 0xFFFFFFFF to a programmable BAR makes it read ~(size−1) in its upper bits, keeps its type bits, and leaves the decoded base unchanged. An unused BAR (size 0) then reads only its type bits.
- R9: Any other write to a programmable BAR keeps the old type bits: bits 1:0 if old bit 0 is 1 (I/O), bits 3:0 otherwise (memory). The remaining bits are taken from the new value.
- R10: A write that leaves a nonzero base (new value with the type bits masked off) loads `bar_base` and pulses `bar_update` for one cycle, in the response cycle. `bar_valid` is high when the base is nonzero and the size is nonzero. A zero base changes neither.
- R11: A BAR flagged legacy reads 0, ignores writes without error, and presents its fixed parameter address on `bar_base` with `bar_valid`=1.
- R12: The expansion ROM register at 0x30 reads 0xFFFFFFFF after 0xFFFFFFFE is written to it. Any other word written there reads back unchanged.
- R13: Every BAR size parameter must be zero or a power of two, or elaboration stops. `bar_size` shows each configured size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 invalid |
| req_addr | input | ADDR_W | Byte offset into configuration space |
| req_wdata | input | 32 | Write data, right-aligned |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_rdata | output | 32 | Read data, right-aligned |
| rsp_err | output | 1 | Request was rejected |
| bar_base | output | 6·32 | Decoded base per BAR, BAR n at bits 32n+31:32n |
| bar_size | output | 6·32 | Configured size per BAR |
| bar_valid | output | 6 | BAR decodes an address range |
| bar_update | output | 6 | One-cycle pulse when a BAR base is loaded |

## Verification
All results are due on the cycle after the rising edge that accepts a request. These results are the response fields, the register state seen through a later read, and the `bar_update` pulse. The bench drives each request at a falling edge, lets exactly one rising edge accept it, and samples at the following falling edge, where the response and any update pulse are present. Register contents are checked with a separate read, whose response is sampled the same way. The stall case holds `rsp_ready` low for several cycles and checks that the response stays and that a request offered meanwhile leaves no trace.

// File: rtl/cfghdr_pkg.sv
package cfghdr_pkg;

  localparam int NUM_BARS  = 6;
  localparam int HDR_BYTES = 64;
  localparam int WORD_W    = 32;

  typedef enum logic [1:0] {
    ACC_B8  = 2'd0,
    ACC_B16 = 2'd1,
    ACC_B32 = 2'd2,
    ACC_BAD = 2'd3
  } acc_size_e;

  // Header offsets that the decode logic depends on
  localparam logic [5:0] OFS_CMD    = 6'h04;
  localparam logic [5:0] OFS_STAT   = 6'h06;
  localparam logic [5:0] OFS_REV    = 6'h08;
  localparam logic [5:0] OFS_CLASS  = 6'h0B;
  localparam logic [5:0] OFS_CLSZ   = 6'h0C;
  localparam logic [5:0] OFS_LAT    = 6'h0D;
  localparam logic [5:0] OFS_ROM    = 6'h30;
  localparam logic [5:0] OFS_INTL   = 6'h3C;
  localparam logic [5:0] OFS_INTP   = 6'h3D;
  localparam logic [5:0] OFS_MINGNT = 6'h3E;
  localparam logic [5:0] OFS_MAXLAT = 6'h3F;
  localparam int         BAR_FIRST  = 16;

  typedef struct packed {
    logic                err;
    logic                cls;
    logic                lat;
    logic                intl;
    logic                cmd;
    logic                stat;
    logic                rom;
    logic [NUM_BARS-1:0] bar;
  } wr_sel_t;

  function automatic logic pow2_or_zero(input logic [31:0] v);
    return (v & (v - 32'd1)) == 32'd0;
  endfunction

endpackage

// File: rtl/cfghdr_access_decode.sv
module cfghdr_access_decode
  import cfghdr_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              write,
  input  logic [1:0]        size,
  input  logic [ADDR_W-1:0] addr,
  output wr_sel_t           sel
);

  if (ADDR_W < 7) begin : g_bad_addr_w
    $error("cfghdr_access_decode: ADDR_W must be at least 7");
  end

  logic [5:0] off;
  logic       beyond;
  logic       bad;

  assign off    = addr[5:0];
  assign beyond = |addr[ADDR_W-1:6];

  always_comb begin
    sel = '0;
    bad = 1'b0;
    unique case (acc_size_e'(size))
      ACC_B8: begin
        if (write) begin
          case (off)
            OFS_CLSZ: sel.cls  = 1'b1;
            OFS_LAT:  sel.lat  = 1'b1;
            OFS_INTL: sel.intl = 1'b1;
            OFS_INTP, OFS_MINGNT, OFS_MAXLAT, OFS_CLASS, OFS_REV: ;
            default:  bad = 1'b1;
          endcase
        end
      end
      ACC_B16: begin
        if (write) begin
          case (off)
            OFS_CMD:  sel.cmd  = 1'b1;
            OFS_STAT: sel.stat = 1'b1;
            OFS_CLSZ: sel.cls  = 1'b1;
            default:  bad = 1'b1;
          endcase
        end
      end
      ACC_B32: begin
        if (write) begin
          if (off == OFS_ROM) begin
            sel.rom = 1'b1;
          end else if (off == OFS_CMD) begin
            sel.cmd  = 1'b1;
            sel.stat = 1'b1;
          end
          for (int i = 0; i < NUM_BARS; i++) begin
            if (off == 6'(BAR_FIRST + 4 * i)) sel.bar[i] = 1'b1;
          end
        end
      end
      default: bad = 1'b1;
    endcase
    if (beyond) bad = 1'b1;
    if (bad) begin
      sel     = '0;
      sel.err = 1'b1;
    end
  end

  // An error must never leave a write strobe behind (R3)
  always_comb begin
    if (sel.err) begin
      assert_err_no_write_R3: assert ({sel.cls, sel.lat, sel.intl, sel.cmd,
                                       sel.stat, sel.rom, sel.bar} == '0)
        else $error("write strobe raised together with error");
    end
  end

  // At most one storage target per write (R5)
  always_comb begin
    assert_one_target_R5: assert ($onehot0({sel.cls, sel.lat, sel.intl,
                                            sel.cmd, sel.rom, sel.bar}))
      else $error("more than one write target selected");
  end

endmodule

// File: rtl/cfghdr_bar.sv
module cfghdr_bar
  import cfghdr_pkg::*;
#(
  parameter logic [31:0] SIZE       = 32'h0,
  parameter bit          LEGACY     = 1'b0,
  parameter logic [31:0] FIXED_ADDR = 32'h0,
  parameter logic [31:0] RESET_VAL  = 32'h0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        we,
  input  logic [31:0] wdata,
  output logic [31:0] rd_val,
  output logic [31:0] base,
  output logic        valid,
  output logic        upd
);

  // R13: sizes must be zero or a power of two
  if (!pow2_or_zero(SIZE)) begin : g_bad_size
    $error("cfghdr_bar: SIZE is neither zero nor a power of two");
  end

  if (LEGACY) begin : g_legacy
    logic unused_legacy;
    assign unused_legacy = ^{clk, rst_n, we, wdata};
    assign rd_val = 32'h0;
    assign base   = FIXED_ADDR;
    assign valid  = 1'b1;
    assign upd    = 1'b0;
  end else begin : g_prog
    localparam logic [31:0] PROBE_MASK = ~(SIZE - 32'd1);

    logic [31:0] bar_q;
    logic [31:0] base_q;
    logic        upd_q;
    logic [31:0] keep;
    logic [31:0] cand;
    logic [31:0] nxt;
    logic [31:0] new_base;
    logic        probe;

    always_comb begin
      keep     = bar_q[0] ? 32'h0000_0003 : 32'h0000_000F;
      probe    = &wdata;
      new_base = wdata & ~keep;
      cand     = probe ? PROBE_MASK : wdata;
      nxt      = (cand & ~keep) | (bar_q & keep);
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        bar_q  <= RESET_VAL;
        base_q <= 32'h0;
        upd_q  <= 1'b0;
      end else begin
        upd_q <= 1'b0;
        if (we) begin
          bar_q <= nxt;
          if (!probe && (new_base != 32'h0)) begin
            base_q <= new_base;
            upd_q  <= 1'b1;
          end
        end
      end
    end

    assign rd_val = bar_q;
    assign base   = base_q;
    assign valid  = (base_q != 32'h0) && (SIZE != 32'h0);
    assign upd    = upd_q;

    assert_probe_keeps_base_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (we && probe) |=> $stable(base_q))
      else $error("size probe moved the decoded base");

    assert_type_bit_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> (bar_q[0] == $past(bar_q[0])))
      else $error("space type bit changed by a write");

    assert_update_has_base_R10: assert property (@(posedge clk) disable iff (!rst_n)
      upd_q |-> (base_q != 32'h0))
      else $error("update pulse with zero base");
  end

endmodule

// File: rtl/cfghdr_regfile.sv
module cfghdr_regfile
  import cfghdr_pkg::*;
#(
  parameter int                     ADDR_W         = 8,
  parameter logic [15:0]            VENDOR_ID      = 16'hC0DE,
  parameter logic [15:0]            DEVICE_ID      = 16'h5A17,
  parameter logic [7:0]             REVISION       = 8'h03,
  parameter logic [7:0]             PROG_IF        = 8'h00,
  parameter logic [7:0]             SUB_CLASS      = 8'h00,
  parameter logic [7:0]             CLASS_CODE     = 8'h02,
  parameter logic [7:0]             HEADER_TYPE    = 8'h00,
  parameter logic [7:0]             BIST_VAL       = 8'h00,
  parameter logic [31:0]            CIS_PTR        = 32'h0,
  parameter logic [15:0]            SUBSYS_VENDOR  = 16'h1234,
  parameter logic [15:0]            SUBSYS_ID      = 16'h0042,
  parameter logic [7:0]             INT_PIN        = 8'h01,
  parameter logic [7:0]             MIN_GRANT      = 8'h00,
  parameter logic [7:0]             MAX_LATENCY    = 8'h00,
  parameter logic [15:0]            CMD_RESET      = 16'h0,
  parameter logic [15:0]            STAT_RESET     = 16'h0,
  parameter logic [7:0]             INT_LINE_RESET = 8'h00,
  parameter logic [31:0]            ROM_RESET      = 32'h0,
  parameter logic [NUM_BARS*32-1:0] BAR_SIZE       = {32'h0, 32'h0010_0000, 32'h8,
                                                      32'h0, 32'h100, 32'h1000},
  parameter logic [NUM_BARS-1:0]    BAR_LEGACY     = 6'b001000,
  parameter logic [NUM_BARS*32-1:0] BAR_FIXED      = {32'h0, 32'h0, 32'h3F8,
                                                      32'h0, 32'h0, 32'h0},
  parameter logic [NUM_BARS*32-1:0] BAR_RESET      = {32'h0, 32'h0, 32'h0,
                                                      32'h0, 32'h1, 32'h8}
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic                     req_write,
  input  logic [1:0]               req_size,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [31:0]              req_wdata,
  output logic                     rsp_valid,
  input  logic                     rsp_ready,
  output logic [31:0]              rsp_rdata,
  output logic                     rsp_err,
  output logic [NUM_BARS*32-1:0]   bar_base,
  output logic [NUM_BARS*32-1:0]   bar_size,
  output logic [NUM_BARS-1:0]      bar_valid,
  output logic [NUM_BARS-1:0]      bar_update
);

  logic        accept;
  wr_sel_t     sel;
  logic [15:0] cmd_q, stat_q;
  logic [7:0]  cls_q, lat_q, intl_q;
  logic [31:0] rom_q;
  logic [31:0] bar_rd [NUM_BARS];
  logic [7:0]  img [HDR_BYTES];
  logic [7:0]  rb [4];
  logic [31:0] rd_data;
  logic [5:0]  off;
  logic        rsp_valid_q, rsp_err_q;
  logic [31:0] rsp_rdata_q;

  assign req_ready = !rsp_valid_q || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign off       = req_addr[5:0];

  cfghdr_access_decode #(.ADDR_W(ADDR_W)) u_decode (
    .write (req_write),
    .size  (req_size),
    .addr  (req_addr),
    .sel   (sel)
  );

  // Writable header fields
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q  <= CMD_RESET;
      stat_q <= STAT_RESET;
      cls_q  <= 8'h00;
      lat_q  <= 8'h00;
      intl_q <= INT_LINE_RESET;
      rom_q  <= ROM_RESET;
    end else if (accept && req_write) begin
      if (sel.cmd)  cmd_q  <= req_wdata[15:0];
      if (sel.stat) stat_q <= (req_size == ACC_B32) ? req_wdata[31:16] : req_wdata[15:0];
      if (sel.cls)  cls_q  <= req_wdata[7:0];
      if (sel.lat)  lat_q  <= req_wdata[7:0];
      if (sel.intl) intl_q <= req_wdata[7:0];
      if (sel.rom)  rom_q  <= (req_wdata == 32'hFFFF_FFFE) ? 32'hFFFF_FFFF : req_wdata;
    end
  end

  // One instance per base address register
  for (genvar i = 0; i < NUM_BARS; i++) begin : g_bar
    cfghdr_bar #(
      .SIZE       (BAR_SIZE [i*32 +: 32]),
      .LEGACY     (BAR_LEGACY[i]),
      .FIXED_ADDR (BAR_FIXED[i*32 +: 32]),
      .RESET_VAL  (BAR_RESET[i*32 +: 32])
    ) u_bar (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (accept && req_write && sel.bar[i]),
      .wdata  (req_wdata),
      .rd_val (bar_rd[i]),
      .base   (bar_base[i*32 +: 32]),
      .valid  (bar_valid[i]),
      .upd    (bar_update[i])
    );
    assign bar_size[i*32 +: 32] = BAR_SIZE[i*32 +: 32];
  end

  // Byte image of the header, little-endian
  always_comb begin
    for (int b = 0; b < HDR_BYTES; b++) img[b] = 8'h00;
    img[0]  = VENDOR_ID[7:0];   img[1]  = VENDOR_ID[15:8];
    img[2]  = DEVICE_ID[7:0];   img[3]  = DEVICE_ID[15:8];
    img[4]  = cmd_q[7:0];       img[5]  = cmd_q[15:8];
    img[6]  = stat_q[7:0];      img[7]  = stat_q[15:8];
    img[8]  = REVISION;         img[9]  = PROG_IF;
    img[10] = SUB_CLASS;        img[11] = CLASS_CODE;
    img[12] = cls_q;            img[13] = lat_q;
    img[14] = HEADER_TYPE;      img[15] = BIST_VAL;
    for (int i = 0; i < NUM_BARS; i++) begin
      for (int k = 0; k < 4; k++) begin
        img[BAR_FIRST + 4*i + k] = bar_rd[i][8*k +: 8];
      end
    end
    for (int k = 0; k < 4; k++) begin
      img[40 + k] = CIS_PTR[8*k +: 8];
      img[48 + k] = rom_q[8*k +: 8];
    end
    img[44] = SUBSYS_VENDOR[7:0]; img[45] = SUBSYS_VENDOR[15:8];
    img[46] = SUBSYS_ID[7:0];     img[47] = SUBSYS_ID[15:8];
    img[60] = intl_q;             img[61] = INT_PIN;
    img[62] = MIN_GRANT;          img[63] = MAX_LATENCY;
  end

  // Right-aligned read data
  always_comb begin
    for (int k = 0; k < 4; k++) rb[k] = img[off + 6'(k)];
    case (acc_size_e'(req_size))
      ACC_B8:  rd_data = {24'h0, rb[0]};
      ACC_B16: rd_data = {16'h0, rb[1], rb[0]};
      ACC_B32: rd_data = {rb[3], rb[2], rb[1], rb[0]};
      default: rd_data = 32'h0;
    endcase
  end

  // Response stage: one cycle after acceptance, held while stalled
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_err_q   <= 1'b0;
      rsp_rdata_q <= 32'h0;
    end else if (accept) begin
      rsp_valid_q <= 1'b1;
      rsp_err_q   <= sel.err;
      rsp_rdata_q <= (req_write || sel.err) ? 32'h0 : rd_data;
    end else if (rsp_ready) begin
      rsp_valid_q <= 1'b0;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_err   = rsp_err_q;
  assign rsp_rdata = rsp_rdata_q;

  assert_rsp_next_R1: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> rsp_valid)
    else $error("response missing one cycle after acceptance");

  assert_rsp_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata) && $stable(rsp_err)))
    else $error("stalled response changed");

  assert_bad_size_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (req_size == 2'd3)) |=> rsp_err)
    else $error("invalid size not flagged");

  assert_high_offset_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (req_addr[ADDR_W-1:6] != '0)) |=>
      (rsp_err && $stable(cmd_q) && $stable(stat_q) && $stable(rom_q) && $stable(intl_q)))
    else $error("access beyond header not rejected");

  assert_rom_probe_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_write && (req_size == 2'd2) && (off == OFS_ROM) &&
     (req_addr[ADDR_W-1:6] == '0) && (req_wdata == 32'hFFFF_FFFE)) |=> (rom_q == 32'hFFFF_FFFF))
    else $error("ROM probe value not converted");

endmodule

// File: tb/cfghdr_regfile_tb_top.sv
module cfghdr_regfile_tb_top;

  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0;
  logic         req_ready;
  logic         req_write = 1'b0;
  logic [1:0]   req_size = 2'd0;
  logic [7:0]   req_addr = 8'h00;
  logic [31:0]  req_wdata = 32'h0;
  logic         rsp_valid;
  logic         rsp_ready = 1'b1;
  logic [31:0]  rsp_rdata;
  logic         rsp_err;
  logic [191:0] bar_base;
  logic [191:0] bar_size;
  logic [5:0]   bar_valid;
  logic [5:0]   bar_update;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  logic [31:0] got_data;
  logic        got_err;
  logic        got_valid;
  logic [5:0]  got_upd;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfghdr_regfile dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_write  (req_write),
    .req_size   (req_size),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .rsp_valid  (rsp_valid),
    .rsp_ready  (rsp_ready),
    .rsp_rdata  (rsp_rdata),
    .rsp_err    (rsp_err),
    .bar_base   (bar_base),
    .bar_size   (bar_size),
    .bar_valid  (bar_valid),
    .bar_update (bar_update)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Drive at a falling edge, accept at the rising edge, sample at the next falling edge
  task automatic access(input bit wr, input logic [1:0] sz, input logic [7:0] a,
                        input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_size = sz; req_addr = a; req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    got_valid = rsp_valid; got_data = rsp_rdata; got_err = rsp_err; got_upd = bar_update;
  endtask

  task automatic rd(input logic [1:0] sz, input logic [7:0] a);
    access(1'b0, sz, a, 32'h0);
  endtask

  task automatic test_reset;
    check("R1 reset rsp_valid", {31'h0, rsp_valid}, 32'h0);
    check("R11 reset bar_valid", {26'h0, bar_valid}, 32'h0000_0008);
    check("R11 legacy base", bar_base[3*32 +: 32], 32'h0000_03F8);
    check("R13 bar0 size", bar_size[0 +: 32], 32'h0000_1000);
    check("R13 bar1 size", bar_size[32 +: 32], 32'h0000_0100);
  endtask

  task automatic test_id_reads;
    rd(2'd2, 8'h00);
    check("R1 response next cycle", {31'h0, got_valid}, 32'h1);
    check("R4 vendor/device word", got_data, 32'h5A17_C0DE);
    rd(2'd0, 8'h0B);
    check("R2 byte class read", got_data, 32'h0000_0002);
    rd(2'd1, 8'h02);
    check("R2 half device read", got_data, 32'h0000_5A17);
    rd(2'd2, 8'h08);
    check("R4 class/rev word", got_data, 32'h0200_0003);
    rd(2'd2, 8'h2C);
    check("R4 subsystem word", got_data, 32'h0042_1234);
    rd(2'd2, 8'h3C);
    check("R4 interrupt word", got_data, 32'h0000_0100);
  endtask

  task automatic test_byte_writes;
    access(1'b1, 2'd0, 8'h0C, 32'h10);
    check("R5 byte write cls no error", {31'h0, got_err}, 32'h0);
    check("R2 write response data zero", got_data, 32'h0);
    access(1'b1, 2'd0, 8'h0D, 32'h40);
    access(1'b1, 2'd0, 8'h3C, 32'h0B);
    rd(2'd2, 8'h0C);
    check("R5 cls/lat stored", got_data, 32'h0000_4010);
    rd(2'd0, 8'h3C);
    check("R5 interrupt line stored", got_data, 32'h0000_000B);
    access(1'b1, 2'd0, 8'h08, 32'hFF);
    check("R5 revision write no error", {31'h0, got_err}, 32'h0);
    rd(2'd0, 8'h08);
    check("R5 revision unchanged", got_data, 32'h0000_0003);
    access(1'b1, 2'd0, 8'h3D, 32'h07);
    rd(2'd0, 8'h3D);
    check("R5 interrupt pin unchanged", got_data, 32'h0000_0001);
    access(1'b1, 2'd0, 8'h00, 32'h55);
    check("R5 byte write to vendor errors", {31'h0, got_err}, 32'h1);
    rd(2'd2, 8'h00);
    check("R4 vendor unchanged", got_data, 32'h5A17_C0DE);
  endtask

  task automatic test_errors;
    rd(2'd3, 8'h00);
    check("R2 bad size err", {31'h0, got_err}, 32'h1);
    check("R2 bad size data zero", got_data, 32'h0);
    rd(2'd2, 8'h40);
    check("R3 read beyond header err", {31'h0, got_err}, 32'h1);
    access(1'b1, 2'd0, 8'h4C, 32'h99);
    check("R3 write beyond header err", {31'h0, got_err}, 32'h1);
    rd(2'd0, 8'h0C);
    check("R3 cls untouched by alias", got_data, 32'h0000_0010);
    access(1'b1, 2'd1, 8'h08, 32'h1111);
    check("R6 half write to revision errors", {31'h0, got_err}, 32'h1);
  endtask

  task automatic test_cmd_status;
    access(1'b1, 2'd2, 8'h04, 32'h1234_0007);
    rd(2'd2, 8'h04);
    check("R7 word cmd/status", got_data, 32'h1234_0007);
    access(1'b1, 2'd1, 8'h04, 32'h0005);
    rd(2'd1, 8'h04);
    check("R6 half command", got_data, 32'h0000_0005);
    access(1'b1, 2'd1, 8'h06, 32'h8000);
    rd(2'd1, 8'h06);
    check("R6 half status", got_data, 32'h0000_8000);
    access(1'b1, 2'd1, 8'h0C, 32'hAB20);
    rd(2'd0, 8'h0C);
    check("R6 half cls low byte", got_data, 32'h0000_0020);
    access(1'b1, 2'd2, 8'h00, 32'hDEAD_BEEF);
    check("R7 read-only word no error", {31'h0, got_err}, 32'h0);
    rd(2'd2, 8'h00);
    check("R7 read-only word unchanged", got_data, 32'h5A17_C0DE);
  endtask

  task automatic test_bars;
    access(1'b1, 2'd2, 8'h10, 32'hFFFF_FFFF);
    check("R8 probe no update", {26'h0, got_upd}, 32'h0);
    rd(2'd2, 8'h10);
    check("R8 mem probe read", got_data, 32'hFFFF_F008);
    access(1'b1, 2'd2, 8'h10, 32'hABCD_1234);
    check("R10 update pulse", {26'h0, got_upd}, 32'h0000_0001);
    check("R10 base loaded", bar_base[0 +: 32], 32'hABCD_1230);
    check("R10 bar0 valid", {31'h0, bar_valid[0]}, 32'h1);
    rd(2'd2, 8'h10);
    check("R9 mem type bits kept", got_data, 32'hABCD_1238);
    check("R10 pulse one cycle", {26'h0, bar_update}, 32'h0);
    access(1'b1, 2'd2, 8'h14, 32'hFFFF_FFFF);
    rd(2'd2, 8'h14);
    check("R8 io probe read", got_data, 32'hFFFF_FF01);
    access(1'b1, 2'd2, 8'h14, 32'h0000_C003);
    check("R10 io update pulse", {26'h0, got_upd}, 32'h0000_0002);
    rd(2'd2, 8'h14);
    check("R9 io type bits kept", got_data, 32'h0000_C001);
    check("R10 io base", bar_base[32 +: 32], 32'h0000_C000);
    access(1'b1, 2'd2, 8'h10, 32'h0000_0007);
    check("R10 zero base no pulse", {26'h0, got_upd}, 32'h0);
    check("R10 base kept on zero", bar_base[0 +: 32], 32'hABCD_1230);
    rd(2'd2, 8'h10);
    check("R9 zero write read", got_data, 32'h0000_0008);
    access(1'b1, 2'd2, 8'h18, 32'hFFFF_FFFF);
    rd(2'd2, 8'h18);
    check("R8 unused bar probe", got_data, 32'h0);
    check("R10 unused bar not valid", {31'h0, bar_valid[2]}, 32'h0);
    access(1'b1, 2'd2, 8'h1C, 32'h1234_5678);
    check("R11 legacy write no error", {31'h0, got_err}, 32'h0);
    check("R11 legacy no pulse", {26'h0, got_upd}, 32'h0);
    rd(2'd2, 8'h1C);
    check("R11 legacy reads zero", got_data, 32'h0);
    check("R11 legacy base fixed", bar_base[3*32 +: 32], 32'h0000_03F8);
  endtask

  task automatic test_rom;
    access(1'b1, 2'd2, 8'h30, 32'hFFFF_FFFE);
    rd(2'd2, 8'h30);
    check("R12 rom probe", got_data, 32'hFFFF_FFFF);
    access(1'b1, 2'd2, 8'h30, 32'h1234_0001);
    rd(2'd2, 8'h30);
    check("R12 rom stored", got_data, 32'h1234_0001);
  endtask

  task automatic test_backpressure;
    logic [31:0] first;
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_write = 1'b0; req_size = 2'd2; req_addr = 8'h00;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    first = rsp_rdata;
    check("R1 stalled valid", {31'h0, rsp_valid}, 32'h1);
    check("R1 ready low while stalled", {31'h0, req_ready}, 32'h0);
    req_valid = 1'b1; req_write = 1'b1; req_size = 2'd0; req_addr = 8'h0C; req_wdata = 32'h55;
    @(posedge clk);
    @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check("R1 stalled data held", rsp_rdata, first);
    check("R1 stalled data value", rsp_rdata, 32'h5A17_C0DE);
    rsp_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R1 released", {31'h0, rsp_valid}, 32'h0);
    rd(2'd0, 8'h0C);
    check("R1 stalled request not taken", got_data, 32'h0000_0020);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_id_reads();
    test_byte_writes();
    test_errors();
    test_cmd_status();
    test_bars();
    test_rom();
    test_backpressure();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

endmodule